// File: doc/BRIEF.md
# External Interrupt Latch Controller

This block collects the external interrupt sources of a small microcontroller into a single pending-request latch. The sources are one active-low interrupt pin and four active-high port pins, and the port pins take part only if a parameter enables them. The CPU sees this latch through one byte-wide status and control register, which holds an enable bit, the read-only pending flag, and a write-only clear bit. A CPU interrupt request is raised only when the flag is pending, the enable bit is on, and the CPU's own interrupt mask is off.

All sources merge into one active-high combined trigger. A second parameter picks between two trigger modes. In edge mode, a change of the combined trigger from inactive to active sets the flag. This means a new request from any source counts only while every other source is inactive. In level mode, the flag is set on every cycle in which the combined trigger is active, which supports wired-OR sources. The flag clears on a vector-fetch acknowledge, on a write of one to the clear bit, or on reset. The raw combined level is also brought out on its own, for instructions that branch on the pin state.

Top module: `ext_irq_latch`

## Requirements
- R1: After reset the register reads 0x80: enable (bit 7) is 1, the pending flag (bit 3) is 0, and the request output is low.
- R2: irq_req is high exactly when the pending flag is set, the enable bit is set, and cpu_imask is low.
- R3: A vec_ack pulse clears the pending flag at the next clock edge, provided no set condition is present in that cycle.
- R4: A register write with bit 1 = 1 clears the flag. A write with bit 1 = 0 leaves the flag unchanged, and so does writing either value into bit 3.
- R5: Bit 7 is read/write and holds the written value. Every bit other than 7 and 3 reads as 0.
- R6: In edge mode (LEVEL_MODE=0), the flag is set one clock after the combined trigger goes from inactive to active. A source that stays active does not set the flag again until the trigger has gone inactive and then active again.
- R7: In level mode (LEVEL_MODE=1), the flag is set at every clock edge at which the combined trigger is active. This set wins over a vec_ack or register clear in the same cycle.
- R8: The combined trigger is active when irq_pin_n is 0 or, with PORT_EN=1, when any bit of port_pins is 1. In edge mode, a source that becomes active while another source is already active does not set the flag.
- R9: With PORT_EN=0, port_pins have no effect on the flag or on pin_level.
- R10: pin_level equals the combined trigger in the same cycle, and the state of the flag has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_pin_n | input | 1 | Synchronised active-low interrupt pin |
| port_pins | input | NUM_PORT | Synchronised active-high port interrupt pins |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| cpu_imask | input | 1 | CPU interrupt mask, 1 = masked |
| vec_ack | input | 1 | Vector-fetch acknowledge strobe |
| irq_req | output | 1 | Interrupt request to the CPU |
| pin_level | output | 1 | Raw combined trigger level |

## Verification
Three configurations run side by side: edge with port pins, level with port pins, and edge without port pins. The bench sweeps every ordered pair of the 32 possible pin states, one state after the other. After each step it checks the flag against the trigger computed for the new state and for the old state. This sweep separates an edge from a level, a true first activation from a source joining one already active, and a port pin that is counted from one that is ignored. Directed sequences then cover the enable and mask combinations of the request, each register write path, re-arming of a held source, and level-set priority over clears.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    localparam int REG_W    = 8;
    localparam int EN_BIT   = 7;
    localparam int FLAG_BIT = 3;
    localparam int CLR_BIT  = 1;

    typedef struct packed {
        logic en;
        logic flag;
    } irq_reg_t;
endpackage

// File: rtl/ext_irq_trig.sv
module ext_irq_trig #(
    parameter int NUM_PORT = 4,
    parameter bit PORT_EN  = 1'b1
) (
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pins,
    output logic                trig_now
);
    logic port_any;

    generate
        if (PORT_EN) begin : g_port
            assign port_any = |port_pins;
        end else begin : g_noport
            logic unused_ports;
            assign unused_ports = ^port_pins;
            assign port_any = 1'b0;
        end
    endgenerate

    assign trig_now = ~irq_pin_n | port_any;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_now,
    output logic set_req
);
    logic trig_d, trig_q;

    always_comb begin
        trig_d = trig_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end

    generate
        if (LEVEL_MODE) begin : g_level
            logic unused_hist;
            assign unused_hist = trig_q;
            assign set_req = trig_now;
        end else begin : g_edge
            assign set_req = trig_now & ~trig_q;
        end
    endgenerate
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
    import ext_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_req,
    input  logic             vec_ack,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    input  logic             cpu_imask,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_req
);
    irq_reg_t st_d, st_q;
    logic     clr_hit;
    logic     unused_wbits;

    assign unused_wbits = ^{reg_wdata[REG_W-2:CLR_BIT+1], reg_wdata[CLR_BIT-1:0]};

    always_comb begin
        st_d    = st_q;
        clr_hit = vec_ack | (reg_wr_en & reg_wdata[CLR_BIT]);
        if (reg_wr_en) st_d.en = reg_wdata[EN_BIT];
        if (set_req)      st_d.flag = 1'b1;
        else if (clr_hit) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata           = '0;
        reg_rdata[EN_BIT]   = st_q.en;
        reg_rdata[FLAG_BIT] = st_q.flag;
    end

    assign irq_req = st_q.flag & st_q.en & ~cpu_imask;
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
    import ext_irq_pkg::*;
#(
    parameter int NUM_PORT   = 4,
    parameter bit PORT_EN    = 1'b1,
    parameter bit LEVEL_MODE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                irq_pin_n,
    input  logic [NUM_PORT-1:0] port_pins,
    input  logic                reg_wr_en,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                cpu_imask,
    input  logic                vec_ack,
    output logic                irq_req,
    output logic                pin_level
);
    logic trig_now;
    logic set_req;

    ext_irq_trig #(.NUM_PORT(NUM_PORT), .PORT_EN(PORT_EN)) u_trig (
        .irq_pin_n (irq_pin_n),
        .port_pins (port_pins),
        .trig_now  (trig_now)
    );

    ext_irq_detect #(.LEVEL_MODE(LEVEL_MODE)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_now (trig_now),
        .set_req  (set_req)
    );

    ext_irq_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (set_req),
        .vec_ack   (vec_ack),
        .reg_wr_en (reg_wr_en),
        .reg_wdata (reg_wdata),
        .cpu_imask (cpu_imask),
        .reg_rdata (reg_rdata),
        .irq_req   (irq_req)
    );

    assign pin_level = trig_now;
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk #(
    parameter bit LEVEL_MODE = 1'b0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_imask,
    input logic       vec_ack,
    input logic       reg_wr_en,
    input logic       wr_en_bit,
    input logic [7:0] reg_rdata,
    input logic       irq_req,
    input logic       pin_level
);
    assert_req_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!cpu_imask && reg_rdata[3] && reg_rdata[7]));

    assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_ack && !pin_level) |=> !reg_rdata[3]);

    assert_en_written_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_rdata[7] == $past(wr_en_bit)));

    assert_zero_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata & 8'h77) == 8'h00);

    assert_idle_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_level && !reg_rdata[3] && !reg_wr_en) |=> !reg_rdata[3]);

    generate
        if (LEVEL_MODE) begin : g_lvl
            assert_level_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
                pin_level |=> reg_rdata[3]);
        end else begin : g_edge
            assert_edge_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pin_level) |=> reg_rdata[3]);
        end
    endgenerate
endmodule

bind ext_irq_latch ext_irq_latch_chk #(.LEVEL_MODE(LEVEL_MODE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_imask (cpu_imask),
    .vec_ack   (vec_ack),
    .reg_wr_en (reg_wr_en),
    .wr_en_bit (reg_wdata[7]),
    .reg_rdata (reg_rdata),
    .irq_req   (irq_req),
    .pin_level (pin_level)
);

// File: tb/ext_irq_latch_tb.sv
module ext_irq_latch_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin_n = 1'b1;
    logic [3:0] port_pins = 4'h0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic       cpu_imask = 1'b0;
    logic       vec_ack = 1'b0;

    logic [7:0] rd_e, rd_l, rd_n;
    logic       req_e, req_l, req_n;
    logic       lvl_e, lvl_l, lvl_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_latch #(.PORT_EN(1'b1), .LEVEL_MODE(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pins(port_pins),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(rd_e),
        .cpu_imask(cpu_imask), .vec_ack(vec_ack), .irq_req(req_e), .pin_level(lvl_e));

    ext_irq_latch #(.PORT_EN(1'b1), .LEVEL_MODE(1'b1)) u_dut_lvl (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pins(port_pins),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(rd_l),
        .cpu_imask(cpu_imask), .vec_ack(vec_ack), .irq_req(req_l), .pin_level(lvl_l));

    ext_irq_latch #(.PORT_EN(1'b0), .LEVEL_MODE(1'b0)) u_dut_np (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .port_pins(port_pins),
        .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(rd_n),
        .cpu_imask(cpu_imask), .vec_ack(vec_ack), .irq_req(req_n), .pin_level(lvl_n));

    function automatic logic trig_of(input logic [4:0] v, input bit use_port);
        return ~v[4] | (use_port & (|v[3:0]));
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pins(input logic [4:0] v);
        irq_pin_n = v[4];
        port_pins = v[3:0];
    endtask

    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1; reg_wdata = d; step();
        reg_wr_en = 1'b0; reg_wdata = 8'h00;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        check("R1 reset reg edge", rd_e, 8'h80);
        check("R1 reset reg level", rd_l, 8'h80);
        check("R1 reset reg noport", rd_n, 8'h80);
        check("R1 reset req", {5'd0, req_e, req_l, req_n}, 8'h00);
        rst_n = 1'b1;
        step();
        check("R1 after release", rd_e, 8'h80);

        // R3: interrupt pin falls, then vector fetch clears while pin idle again
        pins(5'b0_0000); step();
        check("R6 pin fall sets", rd_e, 8'h88);
        pins(5'b1_0000); vec_ack = 1'b1; step(); vec_ack = 1'b0;
        check("R3 ack clears edge", rd_e, 8'h80);
        check("R3 ack clears level", rd_l, 8'h80);

        // R2: request over enable and mask, flag pending
        pins(5'b0_0000); step(); pins(5'b1_0000); step();
        for (int k = 0; k < 4; k++) begin
            wr({k[1], 7'h00});
            cpu_imask = k[0];
            step();
            check("R2 req vs en/mask", {7'd0, req_e}, {7'd0, k[1] & ~k[0]});
        end
        cpu_imask = 1'b0;
        wr(8'h80);
        check("R2 flag kept across writes", rd_e, 8'h88);

        // R4 and R5: writes to flag and clear bit
        wr(8'hFD);
        check("R4 R5 write bit3=1 clr=0", rd_e, 8'h88);
        wr(8'h00);
        check("R5 enable cleared, flag kept", rd_e, 8'h08);
        check("R2 disabled no req", {7'd0, req_e}, 8'h00);
        wr(8'h80);
        wr(8'h02);
        check("R4 clear bit clears, en written 0", rd_e, 8'h00);
        wr(8'h80);
        check("R5 en back", rd_e, 8'h80);

        // R6 re-arm: held low pin cannot retrigger until released
        pins(5'b0_0000); step();
        check("R6 fall sets", rd_e, 8'h88);
        vec_ack = 1'b1; step(); vec_ack = 1'b0;
        check("R6 held pin cleared by ack", rd_e, 8'h80);
        check("R7 level set beats ack", rd_l, 8'h88);
        step();
        check("R6 held pin no retrigger", rd_e, 8'h80);
        wr(8'h82);
        check("R7 level set beats write clear", rd_l, 8'h88);
        // R8: port pin rises while interrupt pin still low
        pins(5'b0_0001); step();
        check("R8 port rise blocked by active pin", rd_e, 8'h80);
        pins(5'b1_0000); step(); pins(5'b0_0000); step();
        check("R6 re-armed fall sets", rd_e, 8'h88);
        pins(5'b1_0000); wr(8'h82);

        // Exhaustive transition sweep over all pin-state pairs
        for (int p = 0; p < 32; p++) begin
            for (int n = 0; n < 32; n++) begin
                logic te_p, te_n, tn_p, tn_n;
                te_p = trig_of(p[4:0], 1'b1); te_n = trig_of(n[4:0], 1'b1);
                tn_p = trig_of(p[4:0], 1'b0); tn_n = trig_of(n[4:0], 1'b0);
                pins(p[4:0]); step();
                wr(8'h82);
                check("R7 level after clear", {7'd0, rd_l[3]}, {7'd0, te_p});
                check("R4 edge after clear", {7'd0, rd_e[3]}, 8'h00);
                pins(n[4:0]); step();
                check("R6 R8 edge flag", {7'd0, rd_e[3]}, {7'd0, te_n & ~te_p});
                check("R7 level flag", {7'd0, rd_l[3]}, {7'd0, te_n | te_p});
                check("R9 noport flag", {7'd0, rd_n[3]}, {7'd0, tn_n & ~tn_p});
                check("R10 pin_level", {5'd0, lvl_e, lvl_l, lvl_n}, {5'd0, te_n, te_n, tn_n});
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule